// File: doc/BRIEF.md
# Autoincrement Operand Temp-Redirect Unit

This unit sits beside the operand decoder of a core that evaluates the operands of one instruction strictly one after another, left to right. When an operand uses a register-modifying mode (post-increment or pre-decrement by the operand size), the new register value is not written to the general register file. It is kept in a per-register temporary slot, and the register is marked as modified. Any later operand of the same instruction that names a marked register is steered to the temporary slot, so a chain of side effects on one register is seen in order.

When the instruction ends without a fault, the unit drains every marked slot into the general register file through one write port, one register per cycle, in ascending register index. It holds a busy flag while it does so. An exception strobe clears all marks at once, which leaves the general registers as they were before the instruction. Interrupts therefore stay precise without renaming.

The general register file lies outside the unit: it drives the value of the register addressed by the current operand, and it takes the commit writes.

Top module: `autoinc_redirect`

## Requirements
- R1: While reset is asserted and after release, `busy_o` and `cmt_we_o` are low, and the first operand after reset reads the general register (`op_from_tmp_o` low).
- R2: A plain-mode operand (mode code 0, and reserved code 3) on an unmodified register reports `op_val_o` and `op_ea_o` equal to `gpr_rdata_i`, and it marks nothing: a following end strobe produces no commit write.
- R3: A post-increment operand (mode code 1) gives `op_ea_o` equal to the source value and records source plus step in the temporary slot, where the size code 0, 1, 2, 3 gives a step of 1, 2, 4, 8 bytes.
- R4: A pre-decrement operand (mode code 2) gives `op_ea_o` equal to the source value minus the step and records that same value in the temporary slot.
- R5: An operand that names a register already modified earlier in the same instruction, in any mode, reads the temporary slot: `op_from_tmp_o` is high and `op_val_o` is the slot value; operands on other registers are unaffected.
- R6: Three successive post-increment longword operands on one register see the start value, then the start value plus 4, then plus 8, and the value committed is the start value plus 12.
- R7: An end strobe without exception starts the commit in the next cycle: one write per cycle for each modified register, in ascending register index, carrying the final slot value, with `busy_o` high in exactly those cycles.
- R8: An exception strobe, before the end strobe or in the same cycle, discards all pending updates: no commit write follows and later operands read the unchanged general registers. An operand offered in the exception cycle is ignored.
- R9: After a commit, all marks are cleared: the next instruction reads each register from the general file, which now holds the committed value.
- R10: While `busy_o` is high, operand, end and exception inputs are ignored: the commit sequence runs to completion unchanged and no new mark is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | An operand is presented this cycle |
| op_reg_i | input | 4 | Register number named by the operand |
| op_mode_i | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 treated as plain |
| op_size_i | input | 2 | Operand size code; step is 1 << code bytes |
| gpr_rdata_i | input | 32 | General register file value for `op_reg_i` |
| end_i | input | 1 | Instruction completes this cycle |
| exc_i | input | 1 | Instruction faults this cycle |
| op_from_tmp_o | output | 1 | Operand source is the temporary slot |
| op_val_o | output | 32 | Register value seen by the operand |
| op_ea_o | output | 32 | Effective address formed from the operand |
| cmt_we_o | output | 1 | Commit write strobe to the general register file |
| cmt_addr_o | output | 4 | Commit write register number |
| cmt_data_o | output | 32 | Commit write data |
| busy_o | output | 1 | Commit drain in progress |

## Verification
The hardest states to reach are an abort landing between two operands of a partly built chain and inputs arriving while the drain runs, since both hide inside state the ports show only later. The bench builds a mixed chain and raises the exception at each operand position in turn, once together with an operand that must be dropped and once together with the end strobe, and then reads the affected registers back to see that no change leaked. A separate scenario holds operand, end and exception inputs high across the drain cycles and checks that the write sequence and the later reads are untouched.

// File: rtl/autoinc_redirect_pkg.sv
package autoinc_redirect_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN   = 2'd0,
    MODE_AUTOINC = 2'd1,
    MODE_AUTODEC = 2'd2,
    MODE_RSVD    = 2'd3
  } op_mode_e;

  // size code -> step in bytes
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/air_operand_path.sv
module air_operand_path
  import autoinc_redirect_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic              busy_i,
  input  logic              exc_i,
  input  logic              src_tmp_i,
  input  logic [DATA_W-1:0] tmp_val_i,
  input  logic [DATA_W-1:0] gpr_val_i,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] ea_o,
  output logic              upd_en_o,
  output logic [DATA_W-1:0] upd_val_o
);

  op_mode_e          mode;
  logic [DATA_W-1:0] step;
  logic              modifies;

  always_comb begin
    mode      = op_mode_e'(mode_i);
    step      = DATA_W'(size_bytes(size_i));
    base_o    = src_tmp_i ? tmp_val_i : gpr_val_i;
    ea_o      = base_o;
    upd_val_o = base_o;
    modifies  = 1'b0;
    unique case (mode)
      MODE_AUTOINC: begin
        upd_val_o = base_o + step;
        modifies  = 1'b1;
      end
      MODE_AUTODEC: begin
        ea_o      = base_o - step;
        upd_val_o = base_o - step;
        modifies  = 1'b1;
      end
      default: ;
    endcase
    upd_en_o = valid_i & modifies & ~busy_i & ~exc_i;
  end

endmodule

// File: rtl/air_tmp_bank.sv
module air_tmp_bank #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_en_i,
  input  logic [REG_W-1:0]    set_idx_i,
  input  logic [DATA_W-1:0]   set_val_i,
  input  logic                clr_all_i,
  input  logic                clr_en_i,
  input  logic [REG_W-1:0]    clr_idx_i,
  input  logic [REG_W-1:0]    rd_idx_i,
  input  logic [REG_W-1:0]    cm_idx_i,
  output logic [NUM_REGS-1:0] flags_o,
  output logic                rd_flag_o,
  output logic [DATA_W-1:0]   rd_val_o,
  output logic [DATA_W-1:0]   cm_val_o
);

  logic [DATA_W-1:0] val_arr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    logic              flag_q;
    logic [DATA_W-1:0] val_q;
    logic              hit_set;
    logic              hit_clr;

    assign hit_set = set_en_i && (set_idx_i == REG_W'(g));
    assign hit_clr = clr_en_i && (clr_idx_i == REG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q <= 1'b0;
        val_q  <= '0;
      end else begin
        if (clr_all_i)    flag_q <= 1'b0;
        else if (hit_set) flag_q <= 1'b1;
        else if (hit_clr) flag_q <= 1'b0;
        if (hit_set) val_q <= set_val_i;
      end
    end

    assign flags_o[g] = flag_q;
    assign val_arr[g] = val_q;
  end

  assign rd_flag_o = flags_o[rd_idx_i];
  assign rd_val_o  = val_arr[rd_idx_i];
  assign cm_val_o  = val_arr[cm_idx_i];

endmodule

// File: rtl/air_commit_seq.sv
module air_commit_seq #(
  parameter int NUM_REGS = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                any_i,
  input  logic [NUM_REGS-1:0] flags_i,
  output logic                busy_o,
  output logic [REG_W-1:0]    pick_o
);

  logic                active_q;
  logic [NUM_REGS-1:0] rest;

  // lowest set index first
  always_comb begin
    pick_o = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (flags_i[i]) pick_o = REG_W'(i);
    end
    rest = flags_i & ~(NUM_REGS'(1) << pick_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       active_q <= 1'b0;
    else if (active_q) active_q <= |rest;
    else if (start_i)  active_q <= any_i;
  end

  assign busy_o = active_q;

endmodule

// File: rtl/autoinc_redirect.sv
module autoinc_redirect #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        op_valid_i,
  input  logic [$clog2(NUM_REGS)-1:0] op_reg_i,
  input  logic [1:0]                  op_mode_i,
  input  logic [1:0]                  op_size_i,
  input  logic [DATA_W-1:0]           gpr_rdata_i,
  input  logic                        end_i,
  input  logic                        exc_i,
  output logic                        op_from_tmp_o,
  output logic [DATA_W-1:0]           op_val_o,
  output logic [DATA_W-1:0]           op_ea_o,
  output logic                        cmt_we_o,
  output logic [$clog2(NUM_REGS)-1:0] cmt_addr_o,
  output logic [DATA_W-1:0]           cmt_data_o,
  output logic                        busy_o
);

  localparam int REG_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0] flags_w;
  logic                rd_flag;
  logic [DATA_W-1:0]   rd_val;
  logic [DATA_W-1:0]   cm_val;
  logic                upd_en;
  logic [DATA_W-1:0]   upd_val;
  logic                busy;
  logic [REG_W-1:0]    pick;
  logic                start;
  logic                abort;

  assign start = end_i & ~exc_i & ~busy;
  assign abort = exc_i & ~busy;

  air_operand_path #(.DATA_W(DATA_W)) u_path (
    .valid_i   (op_valid_i),
    .mode_i    (op_mode_i),
    .size_i    (op_size_i),
    .busy_i    (busy),
    .exc_i     (exc_i),
    .src_tmp_i (rd_flag),
    .tmp_val_i (rd_val),
    .gpr_val_i (gpr_rdata_i),
    .base_o    (op_val_o),
    .ea_o      (op_ea_o),
    .upd_en_o  (upd_en),
    .upd_val_o (upd_val)
  );

  air_tmp_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (upd_en),
    .set_idx_i (op_reg_i),
    .set_val_i (upd_val),
    .clr_all_i (abort),
    .clr_en_i  (busy),
    .clr_idx_i (pick),
    .rd_idx_i  (op_reg_i),
    .cm_idx_i  (pick),
    .flags_o   (flags_w),
    .rd_flag_o (rd_flag),
    .rd_val_o  (rd_val),
    .cm_val_o  (cm_val)
  );

  // an operand in the end cycle joins the commit
  air_commit_seq #(.NUM_REGS(NUM_REGS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .any_i   ((|flags_w) | upd_en),
    .flags_i (flags_w),
    .busy_o  (busy),
    .pick_o  (pick)
  );

  assign op_from_tmp_o = op_valid_i & rd_flag;
  assign cmt_we_o      = busy;
  assign cmt_addr_o    = pick;
  assign cmt_data_o    = cm_val;
  assign busy_o        = busy;

endmodule

// File: rtl/autoinc_redirect_chk.sv
module autoinc_redirect_chk #(
  parameter int NUM_REGS = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                op_valid_i,
  input logic [REG_W-1:0]    op_reg_i,
  input logic [1:0]          op_mode_i,
  input logic                end_i,
  input logic                exc_i,
  input logic                op_from_tmp_o,
  input logic                cmt_we_o,
  input logic [REG_W-1:0]    cmt_addr_o,
  input logic                busy_o,
  input logic [NUM_REGS-1:0] flags_i
);

  // R5
  redirect_same_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_reg_i == $past(op_reg_i)
     && $past(op_valid_i && !busy_o && !exc_i && (op_mode_i == 2'd1 || op_mode_i == 2'd2)))
    |-> op_from_tmp_o);

  // R8
  abort_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i && !busy_o) |=> !busy_o);

  // R8
  abort_reads_gpr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && $past(exc_i && !busy_o)) |-> !op_from_tmp_o);

  // R7
  commit_ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_we_o && $past(cmt_we_o)) |-> cmt_addr_o > $past(cmt_addr_o));

  // R7
  commit_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(end_i && !exc_i));

  // R10
  drain_one_per_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($countones(flags_i) + 1 == $countones($past(flags_i))));

endmodule

bind autoinc_redirect autoinc_redirect_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .op_valid_i    (op_valid_i),
  .op_reg_i      (op_reg_i),
  .op_mode_i     (op_mode_i),
  .end_i         (end_i),
  .exc_i         (exc_i),
  .op_from_tmp_o (op_from_tmp_o),
  .cmt_we_o      (cmt_we_o),
  .cmt_addr_o    (cmt_addr_o),
  .busy_o        (busy_o),
  .flags_i       (flags_w)
);

// File: tb/autoinc_redirect_tb_top.sv
module autoinc_redirect_tb_top;

  localparam int DW = 32;
  localparam int NR = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [3:0]    op_reg;
  logic [1:0]    op_mode;
  logic [1:0]    op_size;
  logic [DW-1:0] gpr_rdata;
  logic          end_s;
  logic          exc_s;
  logic          from_tmp;
  logic [DW-1:0] op_val;
  logic [DW-1:0] op_ea;
  logic          cmt_we;
  logic [3:0]    cmt_addr;
  logic [DW-1:0] cmt_data;
  logic          busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [DW-1:0] rf      [NR];
  logic [DW-1:0] ref_gpr [NR];
  logic [DW-1:0] ref_tmp [NR];
  logic          ref_flag[NR];

  always #10 clk = ~clk;

  autoinc_redirect #(.DATA_W(DW), .NUM_REGS(NR)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .op_valid_i    (op_valid),
    .op_reg_i      (op_reg),
    .op_mode_i     (op_mode),
    .op_size_i     (op_size),
    .gpr_rdata_i   (gpr_rdata),
    .end_i         (end_s),
    .exc_i         (exc_s),
    .op_from_tmp_o (from_tmp),
    .op_val_o      (op_val),
    .op_ea_o       (op_ea),
    .cmt_we_o      (cmt_we),
    .cmt_addr_o    (cmt_addr),
    .cmt_data_o    (cmt_data),
    .busy_o        (busy)
  );

  function automatic logic [DW-1:0] init_val(input int i);
    return 32'h4000_0000 + 32'(i) * 32'h0001_0010;
  endfunction

  // general register file environment, written only by the unit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) rf[i] <= init_val(i);
    end else if (cmt_we) begin
      rf[cmt_addr] <= cmt_data;
    end
  end

  assign gpr_rdata = rf[op_reg];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] r, input logic [1:0] m, input logic [1:0] s,
                       input string tag);
    logic [DW-1:0] src, step, ea, nv;
    @(negedge clk);
    op_valid = 1'b1; op_reg = r; op_mode = m; op_size = s;
    src  = ref_flag[r] ? ref_tmp[r] : ref_gpr[r];
    step = 32'(1) << s;
    ea   = (m == 2'd2) ? src - step : src;
    nv   = (m == 2'd1) ? src + step : src - step;
    #5;
    chk({tag, " src_sel"}, 32'(from_tmp), 32'(ref_flag[r]));
    chk({tag, " val"}, op_val, src);
    chk({tag, " ea"}, op_ea, ea);
    @(posedge clk);
    #1 op_valid = 1'b0;
    if (m == 2'd1 || m == 2'd2) begin
      ref_flag[r] = 1'b1;
      ref_tmp[r]  = nv;
    end
  endtask

  // end strobe; expects writes for ref_flag in ascending order
  task automatic do_end(input string tag);
    @(negedge clk);
    end_s = 1'b1;
    @(posedge clk);
    #1 end_s = 1'b0;
    for (int i = 0; i < NR; i++) begin
      if (ref_flag[i]) begin
        @(negedge clk); #5;
        chk({tag, " busy"}, 32'(busy), 32'd1);
        chk({tag, " we"}, 32'(cmt_we), 32'd1);
        chk({tag, " addr"}, 32'(cmt_addr), 32'(i));
        chk({tag, " data"}, cmt_data, ref_tmp[i]);
        ref_gpr[i]  = ref_tmp[i];
        ref_flag[i] = 1'b0;
      end
    end
    @(negedge clk); #5;
    chk({tag, " done busy"}, 32'(busy), 32'd0);
    chk({tag, " done we"}, 32'(cmt_we), 32'd0);
  endtask

  task automatic do_abort(input logic with_op, input logic with_end, input string tag);
    @(negedge clk);
    exc_s = 1'b1; end_s = with_end;
    if (with_op) begin
      op_valid = 1'b1; op_reg = 4'd6; op_mode = 2'd1; op_size = 2'd2;
    end
    @(posedge clk);
    #1 exc_s = 1'b0; end_s = 1'b0; op_valid = 1'b0;
    for (int i = 0; i < NR; i++) ref_flag[i] = 1'b0;
    repeat (2) begin
      @(negedge clk); #5;
      chk({tag, " no commit"}, 32'({busy, cmt_we}), 32'd0);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; op_valid = 1'b0; op_reg = '0; op_mode = '0; op_size = '0;
    end_s = 1'b0; exc_s = 1'b0;
    for (int i = 0; i < NR; i++) begin
      ref_gpr[i] = init_val(i); ref_tmp[i] = '0; ref_flag[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    chk("R1 reset busy/we", 32'({busy, cmt_we}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk("R1 after release busy/we", 32'({busy, cmt_we}), 32'd0);
    do_op(4'd11, 2'd1, 2'd2, "R1 first op");
    do_abort(1'b0, 1'b0, "R1 cleanup");
  endtask

  task automatic t_plain;
    do_op(4'd3, 2'd0, 2'd2, "R2 plain");
    do_op(4'd3, 2'd3, 2'd1, "R2 reserved mode");
    do_end("R2 end with nothing marked");
  endtask

  task automatic t_triple;
    logic [DW-1:0] start;
    start = ref_gpr[2];
    do_op(4'd2, 2'd1, 2'd2, "R6 first");
    do_op(4'd2, 2'd1, 2'd2, "R6 second");
    do_op(4'd2, 2'd1, 2'd2, "R6 third");
    chk("R6 chain value", ref_tmp[2], start + 32'd12);
    do_end("R7 R6 commit");
    do_op(4'd2, 2'd0, 2'd2, "R9 read after commit");
    chk("R9 committed in file", rf[2], start + 32'd12);
  endtask

  task automatic t_mixed;
    do_op(4'd5, 2'd1, 2'd0, "R3 byte inc");
    do_op(4'd1, 2'd2, 2'd1, "R4 word dec");
    do_op(4'd5, 2'd0, 2'd2, "R5 plain on modified");
    do_op(4'd9, 2'd1, 2'd3, "R3 quad inc");
    do_op(4'd7, 2'd0, 2'd2, "R5 distinct reg");
    do_op(4'd1, 2'd2, 2'd1, "R5 R4 dec again");
    do_end("R7 mixed commit");
    do_op(4'd5, 2'd0, 2'd2, "R9 r5 from file");
    do_op(4'd1, 2'd0, 2'd2, "R9 r1 from file");
    do_end("R9 empty end");
  endtask

  task automatic t_abort_positions;
    for (int k = 0; k <= 3; k++) begin
      if (k > 0) do_op(4'd4, 2'd1, 2'd2, "R8 op0");
      if (k > 1) do_op(4'd4, 2'd1, 2'd2, "R8 op1");
      if (k > 2) do_op(4'd6, 2'd2, 2'd1, "R8 op2");
      do_abort(k < 3, 1'b0, "R8 abort");
      do_end("R8 end after abort");
      do_op(4'd4, 2'd0, 2'd2, "R8 r4 unchanged");
      do_op(4'd6, 2'd0, 2'd2, "R8 r6 unchanged");
      chk("R8 r4 file", rf[4], init_val(4));
    end
    do_op(4'd4, 2'd1, 2'd2, "R8 op before joint");
    do_abort(1'b0, 1'b1, "R8 exc with end");
    do_op(4'd4, 2'd0, 2'd2, "R8 r4 after joint");
  endtask

  task automatic t_busy_ignore;
    do_op(4'd15, 2'd1, 2'd2, "R10 prep r15");
    do_op(4'd0, 2'd2, 2'd0, "R10 prep r0");
    do_op(4'd8, 2'd1, 2'd1, "R10 prep r8");
    @(negedge clk);
    end_s = 1'b1;
    @(posedge clk);
    #1;
    op_valid = 1'b1; op_reg = 4'd0; op_mode = 2'd1; op_size = 2'd3;
    exc_s = 1'b1;
    for (int i = 0; i < NR; i++) begin
      if (ref_flag[i]) begin
        @(negedge clk); #5;
        chk("R10 we", 32'(cmt_we), 32'd1);
        chk("R10 addr", 32'(cmt_addr), 32'(i));
        chk("R10 data", cmt_data, ref_tmp[i]);
        ref_gpr[i]  = ref_tmp[i];
        ref_flag[i] = 1'b0;
        @(posedge clk);
        #1;
      end
    end
    // inputs drop just after the last drain edge
    op_valid = 1'b0; exc_s = 1'b0; end_s = 1'b0;
    @(negedge clk); #5;
    chk("R10 drain finished", 32'({busy, cmt_we}), 32'd0);
    do_op(4'd0, 2'd0, 2'd2, "R10 r0 not remarked");
    do_op(4'd8, 2'd0, 2'd2, "R10 r8 committed");
    do_end("R10 nothing left");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_triple();
    t_mixed();
    t_abort_positions();
    t_busy_ignore();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule